// File: doc/BRIEF.md
# Dual-Buffer DMA Channel

This block is one DMA channel that moves data one word at a time. Each word is read from a source address and then written to a destination address. The channel holds two buffer sets, each made of a source base, a destination base and a byte count. While one buffer set runs, software can load the other. When the running buffer's count reaches zero, the channel moves on to the other buffer without a gap in the stream.

There are three transfer modes. In memory-copy mode a software start bit launches the work. In the two peripheral modes, each read waits for a request line unless handshaking is switched off. Software can also select:
- the access width (8, 16 or 32 bits);
- a hold flag per address, which keeps that address fixed;
- a count of idle cycles inserted between beats.

Two state machines can be read back through a status register:
- a control machine: idle, stall, read, write, wait;
- a buffer machine: none, on, next.

A done event and a next-buffer event are kept as flags, and each can be enabled onto the interrupt line. The channel is finished only when no buffer is loaded and the control machine has parked in stall.

Top module: `dma_dual_buf`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0, the interrupt output is low and no memory access is issued.
- R2: In memory-copy mode (control bits [14:13] = 0), no memory access happens until the control register is written with both enable (bit 3) and start (bit 4) set. Start always reads back as 0.
- R3: Each beat reads the source address in one cycle and writes the word read to the destination address in the next cycle. With no wait states, successive writes are 2 cycles apart. Width code bits [10:9] give the step: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Each beat subtracts the step from the count.
- R4: Without hold, an address advances by the step after every beat. Control bit 11 holds the destination address fixed and bit 12 holds the source address fixed.
- R5: In peripheral modes (bits [14:13] = 1 or 2), a read is issued only while `perReq` is high. Setting bit 24 makes the channel ignore `perReq`.
- R6: A wait-state value N in control bits [31:25] puts N idle cycles between beats, so successive writes are N+2 cycles apart.
- R7: When a buffer finishes and the other buffer is loaded, the channel switches to the other buffer and sets the next-buffer flag (interrupt register bit 2).
- R8: When a buffer finishes and the other buffer is not loaded, the status register shows control state 1 (stall) in bits [3:1] and buffer state 0 in bits [5:4]. It also sets done (status bit 6 and interrupt register bit 1).
- R9: Done is never raised while the control machine is in the read or write state.
- R10: `irq` is (done AND control bit 2) OR (next-buffer AND control bit 21). A write to offset 0x04 clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R11: When enable is cleared, the control machine returns to idle (status bits [3:1] = 0) and memory accesses stop.
- R12: Status bits [5:4] show how many buffers are loaded: 0 is none, 1 is on, 2 is next. A buffer becomes loaded when a non-zero value is written to its byte count: offset 0x10 or 0x14. The source bases are at 0x18 and 0x1C, and the destination bases are at 0x2C and 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memAddr | output | 32 | Memory byte address |
| memRe | output | 1 | Memory read, data expected in the same cycle |
| memWe | output | 1 | Memory write |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| perReq | input | 1 | Peripheral request |
| irq | output | 1 | Interrupt |

## Verification
The assertions take the following for granted:
- Software does not rewrite the byte count of the buffer that is running.
- Software does not clear enable in the same cycle that a final beat completes.
- Memory answers a read in the same cycle that it is issued.

The bench keeps to these rules. It loads buffers only while the channel is idle or stalled, or loads the spare buffer. It waits for done before it disables the channel, except in the single abort test, which stops the channel partway through a long buffer. Its memory model computes the read data straight from the address.

// File: rtl/dma_dual_buf_pkg.sv
package dma_dual_buf_pkg;

  localparam int WS_W = 7;

  typedef enum logic [2:0] {
    CTL_IDLE  = 3'd0,
    CTL_STALL = 3'd1,
    CTL_MEMRD = 3'd2,
    CTL_MEMWR = 3'd3,
    CTL_WAIT  = 3'd4
  } ctlState_e;

  localparam logic [1:0] MODE_COPY = 2'd0;

  typedef struct packed {
    logic [WS_W-1:0] waitStates;
    logic            noHandshake;
    logic [1:0]      reqSel;
    logic            nfbIe;
    logic [1:0]      mode;
    logic            srcHold;
    logic            dstHold;
    logic [1:0]      width;
    logic            enable;
    logic            doneIe;
  } cfg_t;

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic curBuf;
  } strobe_t;

  function automatic logic [2:0] stepOf(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_dual_buf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              perReq,
  input  strobe_t           strobe,
  input  logic [2:0]        ctlState,
  input  logic              doneFlag,
  input  logic              nfbFlag,
  output cfg_t              cfg,
  output logic [1:0]        valid,
  output logic              lastBeat,
  output logic              startWr,
  output logic              intWr,
  output logic [1:0]        intWrData
);

  localparam int NBUF = 2;
  localparam logic [REG_AW-1:0] OFF_CTRL = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] OFF_INT  = REG_AW'(8'h04);
  localparam logic [REG_AW-1:0] OFF_STAT = REG_AW'(8'h0C);

  logic [ADDR_W-1:0] srcA [NBUF];
  logic [ADDR_W-1:0] dstA [NBUF];
  logic [CNT_W-1:0]  cnt  [NBUF];
  logic [31:0]       dataQ;
  logic [2:0]        step;
  logic [1:0]        bufState;

  assign step      = stepOf(cfg.width);
  assign lastBeat  = cnt[strobe.curBuf] <= CNT_W'(step);
  assign bufState  = {valid[0] & valid[1], valid[0] ^ valid[1]};
  assign startWr   = regWe && regAddr == OFF_CTRL && regWdata[4] && regWdata[3];
  assign intWr     = regWe && regAddr == OFF_INT;
  assign intWrData = regWdata[2:1];

  assign memRe    = strobe.rdEn;
  assign memWe    = strobe.wrEn;
  assign memAddr  = strobe.rdEn ? srcA[strobe.curBuf] : dstA[strobe.curBuf];
  assign memWdata = dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg   <= '0;
      valid <= '0;
      dataQ <= '0;
      for (int b = 0; b < NBUF; b++) begin
        srcA[b] <= '0;
        dstA[b] <= '0;
        cnt[b]  <= '0;
      end
    end else begin
      if (regWe && regAddr == OFF_CTRL) begin
        cfg.doneIe      <= regWdata[2];
        cfg.enable      <= regWdata[3];
        cfg.width       <= regWdata[10:9];
        cfg.dstHold     <= regWdata[11];
        cfg.srcHold     <= regWdata[12];
        cfg.mode        <= regWdata[14:13];
        cfg.nfbIe       <= regWdata[21];
        cfg.reqSel      <= regWdata[23:22];
        cfg.noHandshake <= regWdata[24];
        cfg.waitStates  <= regWdata[31:25];
      end
      if (strobe.rdEn) dataQ <= memRdata;
      if (strobe.wrEn) begin
        if (!cfg.srcHold) srcA[strobe.curBuf] <= srcA[strobe.curBuf] + ADDR_W'(step);
        if (!cfg.dstHold) dstA[strobe.curBuf] <= dstA[strobe.curBuf] + ADDR_W'(step);
        cnt[strobe.curBuf] <= lastBeat ? '0 : cnt[strobe.curBuf] - CNT_W'(step);
        if (lastBeat) valid[strobe.curBuf] <= 1'b0;
      end
      for (int b = 0; b < NBUF; b++) begin
        if (regWe && regAddr == REG_AW'(8'h10 + 4 * b)) begin
          cnt[b]   <= regWdata[CNT_W-1:0];
          valid[b] <= |regWdata[CNT_W-1:0];
        end
        if (regWe && regAddr == REG_AW'(8'h18 + 4 * b)) srcA[b] <= regWdata[ADDR_W-1:0];
        if (regWe && regAddr == REG_AW'(8'h2C + 4 * b)) dstA[b] <= regWdata[ADDR_W-1:0];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_CTRL: begin
        regRdData[2]     = cfg.doneIe;
        regRdData[3]     = cfg.enable;
        regRdData[10:9]  = cfg.width;
        regRdData[11]    = cfg.dstHold;
        regRdData[12]    = cfg.srcHold;
        regRdData[14:13] = cfg.mode;
        regRdData[21]    = cfg.nfbIe;
        regRdData[23:22] = cfg.reqSel;
        regRdData[24]    = cfg.noHandshake;
        regRdData[31:25] = cfg.waitStates;
      end
      OFF_INT:  regRdData[2:1] = {nfbFlag, doneFlag};
      OFF_STAT: regRdData[6:1] = {doneFlag, bufState, ctlState};
      REG_AW'(8'h10): regRdData = 32'(cnt[0]);
      REG_AW'(8'h14): regRdData = 32'(cnt[1]);
      REG_AW'(8'h18): regRdData = 32'(srcA[0]);
      REG_AW'(8'h1C): regRdData = 32'(srcA[1]);
      REG_AW'(8'h2C): regRdData = 32'(dstA[0]);
      REG_AW'(8'h30): regRdData = 32'(dstA[1]);
      default: regRdData = '0;
    endcase
  end

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && cfg.mode != MODE_COPY && !cfg.noHandshake) |-> perReq); // R5
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R3

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_dual_buf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cfg_t       cfg,
  input  logic [1:0] valid,
  input  logic       lastBeat,
  input  logic       perReq,
  input  logic       startWr,
  input  logic       intWr,
  input  logic [1:0] intWrData,
  output strobe_t    strobe,
  output logic [2:0] ctlState,
  output logic       doneFlag,
  output logic       nfbFlag,
  output logic       irq
);

  ctlState_e         state;
  logic              curBuf;
  logic              started;
  logic [WS_W-1:0]   waitCnt;
  logic              beatOk;
  logic              otherValid;
  logic              doneSet;
  logic              nfbSet;
  ctlState_e         afterBeat;

  assign otherValid  = valid[~curBuf];
  assign beatOk      = cfg.mode == MODE_COPY || cfg.noHandshake || perReq;
  assign strobe.rdEn = cfg.enable && state == CTL_MEMRD && beatOk;
  assign strobe.wrEn = cfg.enable && state == CTL_MEMWR;
  assign strobe.curBuf = curBuf;
  assign doneSet     = strobe.wrEn && lastBeat && !otherValid;
  assign nfbSet      = strobe.wrEn && lastBeat && otherValid;
  assign afterBeat   = (cfg.waitStates != '0) ? CTL_WAIT : CTL_MEMRD;
  assign ctlState    = state;
  assign irq         = (doneFlag && cfg.doneIe) || (nfbFlag && cfg.nfbIe);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= CTL_IDLE;
      curBuf   <= 1'b0;
      started  <= 1'b0;
      waitCnt  <= '0;
      doneFlag <= 1'b0;
      nfbFlag  <= 1'b0;
    end else begin
      if (!cfg.enable) begin
        state   <= CTL_IDLE;
        started <= 1'b0;
      end else begin
        case (state)
          CTL_IDLE, CTL_STALL: begin
            if ((|valid) && (cfg.mode != MODE_COPY || started)) begin
              state <= CTL_MEMRD;
              if (!valid[curBuf]) curBuf <= ~curBuf;
            end
          end
          CTL_MEMRD: if (beatOk) state <= CTL_MEMWR;
          CTL_MEMWR: begin
            waitCnt <= cfg.waitStates;
            if (lastBeat && !otherValid) begin
              state   <= CTL_STALL;
              started <= 1'b0;
            end else begin
              state <= afterBeat;
              if (lastBeat) curBuf <= ~curBuf;
            end
          end
          CTL_WAIT: begin
            waitCnt <= waitCnt - 1'b1;
            if (waitCnt <= WS_W'(1)) state <= CTL_MEMRD;
          end
          default: state <= CTL_IDLE;
        endcase
      end
      if (startWr) started <= 1'b1;
      if (intWr) begin
        doneFlag <= doneFlag & intWrData[0];
        nfbFlag  <= nfbFlag & intWrData[1];
      end
      if (doneSet) doneFlag <= 1'b1;
      if (nfbSet)  nfbFlag  <= 1'b1;
    end
  end

  AST_DONE_AT_STALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (state == CTL_STALL && valid == 2'b00)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (state != CTL_MEMRD && state != CTL_MEMWR)); // R9
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> state == CTL_IDLE); // R11
  AST_NFB_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    nfbSet |=> curBuf != $past(curBuf)); // R7

endmodule

// File: rtl/dma_dual_buf.sv
module dma_dual_buf
  import dma_dual_buf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              perReq,
  output logic              irq
);

  strobe_t    strobe;
  cfg_t       cfg;
  logic [2:0] ctlState;
  logic       doneFlag;
  logic       nfbFlag;
  logic [1:0] valid;
  logic       lastBeat;
  logic       startWr;
  logic       intWr;
  logic [1:0] intWrData;

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_datapath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdData(regRdData), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .perReq(perReq), .strobe(strobe),
    .ctlState(ctlState), .doneFlag(doneFlag), .nfbFlag(nfbFlag), .cfg(cfg),
    .valid(valid), .lastBeat(lastBeat), .startWr(startWr), .intWr(intWr),
    .intWrData(intWrData)
  );

  dma_control u_control (
    .clk(clk), .rstN(rstN), .cfg(cfg), .valid(valid), .lastBeat(lastBeat),
    .perReq(perReq), .startWr(startWr), .intWr(intWr), .intWrData(intWrData),
    .strobe(strobe), .ctlState(ctlState), .doneFlag(doneFlag), .nfbFlag(nfbFlag),
    .irq(irq)
  );

endmodule

// File: tb/dma_dual_buf_bench.sv
module dma_dual_buf_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdData;
  logic [31:0] memAddr;
  logic        memRe, memWe;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        perReq = 1'b0;
  logic        irq;

  int vecs = 0;
  int fails = 0;
  int nWrites = 0;
  int cycle = 0;
  bit sbOn = 1'b1;
  logic [63:0] expQ[$];
  int stampQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37) ^ 32'h5A5A_0000;
  endfunction
  assign memRdata = pat(memAddr);

  dma_dual_buf u_dma_dual_buf (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdData(regRdData), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .perReq(perReq), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every memory write is compared with the oldest expected item
  always @(negedge clk) begin
    if (rstN && memWe) begin
      nWrites++;
      stampQ.push_back(cycle);
      if (sbOn) begin
        if (expQ.size() == 0) chk("R3 unexpected write", memAddr, 32'hx);
        else begin
          logic [63:0] e;
          e = expQ.pop_front();
          chk("R3/R4 write addr", memAddr, e[63:32]);
          chk("R3 write data", memWdata, e[31:0]);
        end
      end
    end
  end

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pushBeats(input logic [31:0] src, input logic [31:0] dst, input int n,
                           input int step, input bit sHold, input bit dHold);
    for (int i = 0; i < n; i++) begin
      logic [31:0] s, d;
      s = sHold ? src : src + 32'(i * step);
      d = dHold ? dst : dst + 32'(i * step);
      expQ.push_back({d, pat(s)});
    end
  endtask

  task automatic loadBuf(input int b, input logic [31:0] c, input logic [31:0] s,
                         input logic [31:0] d);
    regWrite(6'(8'h18 + 4 * b), s);
    regWrite(6'(8'h2C + 4 * b), d);
    regWrite(6'(8'h10 + 4 * b), c);
  endtask

  task automatic waitBit(input logic [5:0] a, input int bitN, input string req);
    logic [31:0] r;
    int n;
    n = 0;
    r = '0;
    while (!r[bitN] && n < 2000) begin
      regRead(a, r);
      n++;
    end
    if (!r[bitN]) chk(req, r, 32'hx);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    int w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(6'h0C, r); chk("R1 status after reset", r, 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 no access after reset", 32'({memRe, memWe}), 32'h0);

    // R2/R3 copy mode, 32-bit, needs start
    loadBuf(0, 12, 32'h100, 32'h200);
    regRead(6'h0C, r); chk("R12 one buffer loaded", 32'(r[5:4]), 32'h1);
    pushBeats(32'h100, 32'h200, 3, 4, 0, 0);
    w0 = nWrites;
    regWrite(6'h00, (32'd2 << 9) | 32'h0C);
    repeat (10) @(negedge clk);
    chk("R2 no write without start", 32'(nWrites - w0), 32'h0);
    regRead(6'h00, r); chk("R2 start reads zero", 32'(r[4]), 32'h0);
    stampQ.delete();
    regWrite(6'h00, (32'd2 << 9) | 32'h1C);
    waitBit(6'h0C, 6, "R8 done timeout");
    chk("R3 all beats written", 32'(expQ.size()), 32'h0);
    chk("R3 back-to-back gap", 32'(stampQ[1] - stampQ[0]), 32'd2);
    regRead(6'h0C, r); chk("R8 status at end", r, 32'h42);
    regRead(6'h04, r); chk("R8 done flag", r, 32'h2);
    chk("R10 irq with done enabled", 32'(irq), 32'h1);
    regWrite(6'h04, 32'h0);
    chk("R10 irq after clear", 32'(irq), 32'h0);
    regRead(6'h0C, r); chk("R10 done cleared in status", 32'(r[6]), 32'h0);

    // R5/R4 to-peripheral, 8-bit, destination held, handshake
    loadBuf(0, 3, 32'h40, 32'h300);
    pushBeats(32'h40, 32'h300, 3, 1, 0, 1);
    w0 = nWrites;
    regWrite(6'h00, (32'd1 << 13) | (32'd1 << 11) | 32'h8);
    repeat (10) @(negedge clk);
    chk("R5 held off without request", 32'(nWrites - w0), 32'h0);
    perReq = 1'b1;
    waitBit(6'h0C, 6, "R5 done timeout");
    chk("R4 dest hold beats", 32'(expQ.size()), 32'h0);
    perReq = 1'b0;
    regWrite(6'h04, 32'h0);

    // R4/R5 from-peripheral, 16-bit, source held, no handshake
    loadBuf(0, 4, 32'h500, 32'h600);
    pushBeats(32'h500, 32'h600, 2, 2, 1, 0);
    regWrite(6'h00, (32'd1 << 24) | (32'd2 << 13) | (32'd1 << 12) | (32'd1 << 9) | 32'h8);
    waitBit(6'h0C, 6, "R5 no-handshake done timeout");
    chk("R4 source hold beats", 32'(expQ.size()), 32'h0);
    regWrite(6'h04, 32'h0);

    // R11 disable, then R7 dual buffer
    regWrite(6'h00, 32'h0);
    regRead(6'h0C, r); chk("R11 idle after disable", 32'(r[3:1]), 32'h0);
    loadBuf(0, 8, 32'h700, 32'h800);
    loadBuf(1, 4, 32'h900, 32'hA00);
    regRead(6'h0C, r); chk("R12 two buffers loaded", 32'(r[5:4]), 32'h2);
    pushBeats(32'h700, 32'h800, 2, 4, 0, 0);
    pushBeats(32'h900, 32'hA00, 1, 4, 0, 0);
    regWrite(6'h00, (32'd1 << 21) | (32'd2 << 9) | 32'h18);
    waitBit(6'h04, 2, "R7 next-buffer timeout");
    chk("R7 irq on next-buffer", 32'(irq), 32'h1);
    waitBit(6'h0C, 6, "R7 done timeout");
    chk("R7 both buffers written", 32'(expQ.size()), 32'h0);
    regRead(6'h04, r); chk("R7 flags after two buffers", r, 32'h6);
    regWrite(6'h04, 32'h4);
    regRead(6'h04, r); chk("R10 partial clear", r, 32'h4);
    regWrite(6'h04, 32'h0);

    // R6 wait states
    loadBuf(0, 12, 32'hB00, 32'hC00);
    pushBeats(32'hB00, 32'hC00, 3, 4, 0, 0);
    stampQ.delete();
    regWrite(6'h00, (32'd3 << 25) | (32'd2 << 9) | 32'h18);
    waitBit(6'h0C, 6, "R6 done timeout");
    chk("R6 wait beats", 32'(expQ.size()), 32'h0);
    chk("R6 first gap", 32'(stampQ[1] - stampQ[0]), 32'd5);
    chk("R6 second gap", 32'(stampQ[2] - stampQ[1]), 32'd5);
    regWrite(6'h04, 32'h0);

    // R11 abort mid-transfer
    sbOn = 1'b0;
    loadBuf(0, 400, 32'h1000, 32'h2000);
    regWrite(6'h00, 32'h18);
    repeat (10) @(negedge clk);
    regWrite(6'h00, 32'h0);
    regRead(6'h0C, r); chk("R11 idle after abort", 32'(r[3:1]), 32'h0);
    w0 = nWrites;
    repeat (10) @(negedge clk);
    chk("R11 no writes after abort", 32'(nWrites - w0), 32'h0);

    finishRun();
  end

endmodule